// File: doc/BRIEF.md
# Slave-Mode Timer Counter

This block is the counting core of a general-purpose timer. It keeps a counter of parameterized width (16 bits by default) and decides on every clock whether the counter holds, steps up, steps down or is cleared. A 3-bit mode input picks one of eight ways to drive the counter. The counter can run freely on the internal clock. It can follow a two-channel position encoder in one of three variants. It can be cleared, gated or started by a trigger line. It can also count rising edges of the trigger as an external clock.

The two channel inputs and the trigger are asynchronous to the timer clock. Each one passes through a two-flop synchronizer and then an edge detector, and every detected edge gives one clock of count enable. A software enable bit, a clear for the triggered-start latch and an auto-reload limit come straight from the surrounding register file. The outputs are the count, a direction flag and a one-cycle update pulse that marks each wrap or restart.

Top module: `slave_mode_counter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cnt_o`, `dir_o` and `upd_o` are all 0.
- R2: With `mode`=0 the counter goes up by one on every clock while `cnt_en` is 1, and holds while `cnt_en` is 0.
- R3: Counting up from a value at or above `arr` loads 0 and raises `upd_o` for exactly that one cycle.
- R4: Counting down from 0 loads `arr` and raises `upd_o` for that one cycle.
- R5: With `mode`=1 and `cnt_en`=1, each edge of `ci0` (rising or falling) steps the counter once. The step is down when synchronized `ci1` is 1 and up when it is 0. An input change before clock edge k shows at the outputs after edge k+2.
- R6: With `mode`=2 and `cnt_en`=1, each edge of `ci1` steps the counter once, down when synchronized `ci0` is 1 and up when it is 0.
- R7: With `mode`=3 and `cnt_en`=1, edges of either channel step the counter, and the level of the other channel sets the direction. When both channels change in the same cycle, only the `ci0` rule applies.
- R8: With `mode`=4, a rising edge of `trig` loads 0 and pulses `upd_o`, whatever the value of `cnt_en`. In every other cycle the counter counts up as in mode 0.
- R9: With `mode`=5 the counter goes up by one per clock only while `cnt_en` is 1 and synchronized `trig` is 1.
- R10: With `mode`=6 a rising edge of `trig` sets a run latch, and from the next clock the counter goes up by one per clock whatever `cnt_en` is. `run_clr` clears the latch in any mode, and the clear wins over a same-cycle trigger edge.
- R11: With `mode`=7 and `cnt_en`=1 the counter goes up by one per rising edge of `trig` and ignores falling edges.
- R12: `dir_o` is 1 for a down step. It is updated by each encoder step in modes 1 to 3, held between encoder steps, and forced to 0 in modes 0 and 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Software counter enable |
| run_clr | input | 1 | Clears the triggered-start run latch |
| mode | input | 3 | Slave mode select (0 to 7) |
| arr | input | W | Auto-reload limit |
| ci0 | input | 1 | Filtered channel 0, asynchronous |
| ci1 | input | 1 | Filtered channel 1, asynchronous |
| trig | input | 1 | Trigger input, asynchronous |
| cnt_o | output | W | Counter value |
| dir_o | output | 1 | Direction, 1 = down |
| upd_o | output | 1 | One-cycle update event |

## Verification
The assertions check the following on every cycle:
- the counter moves at most one step, or jumps only to 0 or to the reload limit;
- an update pulse always coincides with one of those two jump values;
- the counter holds in mode 0 without the enable and in gated mode with the trigger low;
- the direction flag is clear in the non-encoder modes.

Only the scenarios can show the rest:
- which input counts in each encoder variant, and which input sets the direction;
- the simultaneous-edge priority;
- restart overriding the enable;
- the run latch with its clear-wins rule;
- trigger-edge counting;
- the two-cycle synchronizer latency.

The scenarios show these against a behavioural model that is compared on every clock.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [2:0] {
    SM_INTERNAL  = 3'd0,
    SM_ENC_A     = 3'd1,
    SM_ENC_B     = 3'd2,
    SM_ENC_AB    = 3'd3,
    SM_RESTART   = 3'd4,
    SM_GATED     = 3'd5,
    SM_TRIGGERED = 3'd6,
    SM_EXTCLK    = 3'd7
  } slave_mode_e;

  localparam int IDX_CI0  = 0;
  localparam int IDX_CI1  = 1;
  localparam int IDX_TRIG = 2;
  localparam int NUM_IN   = 3;
endpackage

// File: rtl/smc_sync_edge.sv
module smc_sync_edge #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] tog,
  output logic [N-1:0] rise
);
  logic [STAGES-1:0][N-1:0] pipe;
  logic [N-1:0]             prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl = pipe[STAGES-1];

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign tog[i]  = lvl[i] ^ prev[i];
    assign rise[i] = lvl[i] & ~prev[i];
  end
endmodule

// File: rtl/smc_step_ctrl.sv
module smc_step_ctrl
  import smc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  slave_mode_e       mode,
  input  logic              cnt_en,
  input  logic              run_clr,
  input  logic [NUM_IN-1:0] lvl,
  input  logic [NUM_IN-1:0] tog,
  input  logic [NUM_IN-1:0] rise,
  output logic              step_up,
  output logic              step_dn,
  output logic              reload,
  output logic              dir_o
);
  logic run_q;
  logic enc_step;
  logic enc_down;
  logic free_up;
  logic enc_mode;

  assign enc_mode = (mode == SM_ENC_A) || (mode == SM_ENC_B) || (mode == SM_ENC_AB);

  always_comb begin
    enc_step = 1'b0;
    enc_down = 1'b0;
    free_up  = 1'b0;
    reload   = 1'b0;
    unique case (mode)
      SM_INTERNAL: free_up = cnt_en;
      SM_ENC_A: begin
        enc_step = cnt_en & tog[IDX_CI0];
        enc_down = lvl[IDX_CI1];
      end
      SM_ENC_B: begin
        enc_step = cnt_en & tog[IDX_CI1];
        enc_down = lvl[IDX_CI0];
      end
      SM_ENC_AB: begin
        enc_step = cnt_en & (tog[IDX_CI0] | tog[IDX_CI1]);
        enc_down = tog[IDX_CI0] ? lvl[IDX_CI1] : lvl[IDX_CI0];
      end
      SM_RESTART: begin
        reload  = rise[IDX_TRIG];
        free_up = cnt_en & ~rise[IDX_TRIG];
      end
      SM_GATED:     free_up = cnt_en & lvl[IDX_TRIG];
      SM_TRIGGERED: free_up = run_q;
      SM_EXTCLK:    free_up = cnt_en & rise[IDX_TRIG];
      default: ;
    endcase
  end

  assign step_up = free_up | (enc_step & ~enc_down);
  assign step_dn = enc_step & enc_down;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
    end else if (run_clr) begin
      run_q <= 1'b0;
    end else if (mode == SM_TRIGGERED && rise[IDX_TRIG]) begin
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enc_mode) begin
      dir_o <= 1'b0;
    end else if (enc_step) begin
      dir_o <= enc_down;
    end
  end
endmodule

// File: rtl/smc_count_core.sv
module smc_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] arr,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic         reload,
  output logic [W-1:0] cnt_o,
  output logic         upd_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (reload) begin
        cnt_o <= '0;
        upd_o <= 1'b1;
      end else if (step_up) begin
        if (cnt_o >= arr) begin
          cnt_o <= '0;
          upd_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o + ONE;
        end
      end else if (step_dn) begin
        if (cnt_o == '0) begin
          cnt_o <= arr;
          upd_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/slave_mode_counter.sv
module slave_mode_counter
  import smc_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         run_clr,
  input  logic [2:0]   mode,
  input  logic [W-1:0] arr,
  input  logic         ci0,
  input  logic         ci1,
  input  logic         trig,
  output logic [W-1:0] cnt_o,
  output logic         dir_o,
  output logic         upd_o
);
  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] lvl;
  logic [NUM_IN-1:0] tog;
  logic [NUM_IN-1:0] rise;
  logic              step_up;
  logic              step_dn;
  logic              reload;
  logic              trig_lvl;

  assign raw_in[IDX_CI0]  = ci0;
  assign raw_in[IDX_CI1]  = ci1;
  assign raw_in[IDX_TRIG] = trig;
  assign trig_lvl         = lvl[IDX_TRIG];

  smc_sync_edge #(.N(NUM_IN), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_in),
    .lvl  (lvl),
    .tog  (tog),
    .rise (rise)
  );

  smc_step_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .mode    (slave_mode_e'(mode)),
    .cnt_en  (cnt_en),
    .run_clr (run_clr),
    .lvl     (lvl),
    .tog     (tog),
    .rise    (rise),
    .step_up (step_up),
    .step_dn (step_dn),
    .reload  (reload),
    .dir_o   (dir_o)
  );

  smc_count_core #(.W(W)) core_i (
    .clk     (clk),
    .rst     (rst),
    .arr     (arr),
    .step_up (step_up),
    .step_dn (step_dn),
    .reload  (reload),
    .cnt_o   (cnt_o),
    .upd_o   (upd_o)
  );
endmodule

// File: rtl/smc_checker.sv
module smc_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic [2:0]   mode,
  input logic [W-1:0] arr,
  input logic         trig_lvl,
  input logic [W-1:0] cnt_o,
  input logic         dir_o,
  input logic         upd_o
);
  // R2: no enable in mode 0 means no movement
  assert_hold_off_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 && !cnt_en) |=> $stable(cnt_o));

  // R3 and R4: the counter moves one step, or jumps to 0 or to the reload limit
  assert_step_size_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_o) |-> (cnt_o == W'($past(cnt_o) + W'(1)) ||
                         cnt_o == W'($past(cnt_o) - W'(1)) ||
                         cnt_o == '0 || cnt_o == $past(arr)));

  // R4: an update pulse coincides with one of the wrap or restart values
  assert_upd_value_R4: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> (cnt_o == '0 || cnt_o == $past(arr)));

  // R9: gated mode with the synchronized trigger low holds the count
  assert_pause_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd5 && !trig_lvl) |=> $stable(cnt_o));

  // R12: direction is clear outside the encoder modes
  assert_dir_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 || mode[2]) |=> !dir_o);
endmodule

bind slave_mode_counter smc_checker #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cnt_en   (cnt_en),
  .mode     (mode),
  .arr      (arr),
  .trig_lvl (trig_lvl),
  .cnt_o    (cnt_o),
  .dir_o    (dir_o),
  .upd_o    (upd_o)
);

// File: tb/slave_mode_counter_tb_top.sv
`timescale 1ns/1ps
module slave_mode_counter_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0;
  logic         run_clr = 1'b0;
  logic [2:0]   mode = 3'd0;
  logic [W-1:0] arr = 16'd5;
  logic         ci0 = 1'b0;
  logic         ci1 = 1'b0;
  logic         trig = 1'b0;
  logic [W-1:0] cnt_o;
  logic         dir_o;
  logic         upd_o;

  int    vectors = 0;
  int    misses  = 0;
  int    cycles  = 0;
  bit    done    = 1'b0;
  string tag     = "R1";

  always #5 clk = ~clk;

  slave_mode_counter #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .run_clr(run_clr), .mode(mode),
    .arr(arr), .ci0(ci0), .ci1(ci1), .trig(trig),
    .cnt_o(cnt_o), .dir_o(dir_o), .upd_o(upd_o)
  );

  // Behavioural reference model: input history queues, integer counter
  bit q0[$], q1[$], qt[$];
  int m_cnt = 0;
  bit m_dir = 0, m_upd = 0, m_run = 0;

  always @(posedge clk) begin
    if (rst) begin
      q0 = '{0, 0, 0}; q1 = '{0, 0, 0}; qt = '{0, 0, 0};
      m_cnt = 0; m_dir = 0; m_upd = 0; m_run = 0;
    end else begin
      // q[1] is the synchronized level, q[0] the level one clock older
      bit l0, l1, lt, e0, e1, rt, rel;
      int step;
      l0 = q0[1]; l1 = q1[1]; lt = qt[1];
      e0 = q0[1] != q0[0]; e1 = q1[1] != q1[0]; rt = qt[1] && !qt[0];
      step = 0; rel = 0;
      case (mode)
        3'd0: if (cnt_en) step = 1;
        3'd1: if (cnt_en && e0) begin step = l1 ? -1 : 1; m_dir = l1; end
        3'd2: if (cnt_en && e1) begin step = l0 ? -1 : 1; m_dir = l0; end
        3'd3: if (cnt_en && e0) begin step = l1 ? -1 : 1; m_dir = l1; end
              else if (cnt_en && e1) begin step = l0 ? -1 : 1; m_dir = l0; end
        3'd4: if (rt) rel = 1; else if (cnt_en) step = 1;
        3'd5: if (cnt_en && lt) step = 1;
        3'd6: if (m_run) step = 1;
        default: if (cnt_en && rt) step = 1;
      endcase
      if (mode == 3'd0 || mode >= 3'd4) m_dir = 0;
      if (run_clr) m_run = 0;
      else if (mode == 3'd6 && rt) m_run = 1;
      m_upd = 0;
      if (rel) begin m_cnt = 0; m_upd = 1; end
      else if (step == 1) begin
        if (m_cnt >= int'(arr)) begin m_cnt = 0; m_upd = 1; end else m_cnt++;
      end else if (step == -1) begin
        if (m_cnt == 0) begin m_cnt = int'(arr); m_upd = 1; end else m_cnt--;
      end
      void'(q0.pop_front()); q0.push_back(ci0);
      void'(q1.pop_front()); q1.push_back(ci1);
      void'(qt.pop_front()); qt.push_back(trig);
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      vectors++;
      if (cnt_o !== W'(m_cnt) || dir_o !== m_dir || upd_o !== m_upd) begin
        misses++;
        $display("FAIL %s t=%0t cnt=%0d dir=%0b upd=%0b expected cnt=%0d dir=%0b upd=%0b",
                 tag, $time, cnt_o, dir_o, upd_o, m_cnt, m_dir, m_upd);
      end
    end
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      misses++;
      $display("FAIL watchdog expired during %s", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    tick(3);
    // R1: outputs zero while reset is held
    vectors++;
    if (cnt_o !== '0 || dir_o !== 1'b0 || upd_o !== 1'b0) begin
      misses++;
      $display("FAIL R1 in reset cnt=%0d dir=%0b upd=%0b expected 0 0 0", cnt_o, dir_o, upd_o);
    end
    rst = 1'b0;
    tick(3);

    tag = "R2"; mode = 3'd0; cnt_en = 1'b1; tick(4);
    tag = "R3"; tick(12);                       // wraps at arr=5
    tag = "R2"; cnt_en = 1'b0; tick(5);

    tag = "R5"; mode = 3'd1; cnt_en = 1'b1; ci1 = 1'b0;
    for (int i = 0; i < 8; i++) begin ci0 = ~ci0; tick(2); end
    tag = "R4"; ci1 = 1'b1; tick(3);
    for (int i = 0; i < 9; i++) begin ci0 = ~ci0; tick(3); end
    tag = "R5"; ci1 = 1'b0; ci0 = ~ci0; tick(1); ci0 = ~ci0; tick(4);

    tag = "R12"; cnt_en = 1'b0; ci0 = ~ci0; tick(4); cnt_en = 1'b1;

    tag = "R6"; mode = 3'd2; ci0 = 1'b1;
    for (int i = 0; i < 6; i++) begin ci1 = ~ci1; tick(2); end
    ci0 = 1'b0; tick(3);
    for (int i = 0; i < 5; i++) begin ci1 = ~ci1; tick(2); end
    ci0 = ~ci0; tick(4);                        // ci0 edge ignored in mode 2

    tag = "R7"; mode = 3'd3;
    for (int i = 0; i < 6; i++) begin
      ci0 = ~ci0; tick(2); ci1 = ~ci1; tick(2);
    end
    for (int i = 0; i < 4; i++) begin ci0 = ~ci0; ci1 = ~ci1; tick(3); end

    tag = "R12"; mode = 3'd0; cnt_en = 1'b0; tick(3);

    tag = "R8"; arr = 16'd40; mode = 3'd4; cnt_en = 1'b1; tick(6);
    trig = 1'b1; tick(4); trig = 1'b0; tick(5);
    cnt_en = 1'b0; trig = 1'b1; tick(4); trig = 1'b0; tick(3);

    tag = "R9"; mode = 3'd5; cnt_en = 1'b1; tick(4);
    trig = 1'b1; tick(7); trig = 1'b0; tick(5);
    trig = 1'b1; cnt_en = 1'b0; tick(4); trig = 1'b0; tick(3);

    tag = "R10"; mode = 3'd6; arr = 16'd9; tick(4);
    trig = 1'b1; tick(3); trig = 1'b0; tick(12);
    run_clr = 1'b1; tick(1); run_clr = 1'b0; tick(5);
    trig = 1'b1; tick(2); run_clr = 1'b1; tick(2); run_clr = 1'b0; tick(5);
    trig = 1'b0; tick(3);

    tag = "R11"; mode = 3'd7; cnt_en = 1'b1; arr = 16'd3;
    for (int i = 0; i < 10; i++) begin trig = ~trig; tick(3); end
    cnt_en = 1'b0; trig = ~trig; tick(3); trig = ~trig; tick(4);

    tag = "R3"; mode = 3'd0; cnt_en = 1'b1; arr = 16'd2; tick(10);
    arr = 16'd0; tick(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule